// File: doc/BRIEF.md
# Burst Read Responder

This block is the device side of a burst read from a lookup memory that holds two arrays, one of data words and one of mask words. A host issues a read command together with an address word on a shared 68-bit bus. The block checks that the device-select field of that word names this device, picks the array, and then plays out a fixed cycle sequence. In that sequence it takes over the shared bus, returns one word per access, and signals each word with an acknowledge strobe and the last word with an end-of-transfer strobe. Each of the three outputs has its own enable, so the block can share the bus and both strobe lines with other devices.

The start address and the access count come from a burst register that the host loads while the block is idle. The array address is taken from a counter in that register. The counter advances by one per access and keeps its value after the burst ends. The arrays sit outside the block behind a synchronous read port with one cycle of latency.

Top module: `burst_read_responder`

## Requirements
- R1: While reset is held and after its release, `dq_oe`, `ack_oe`, `eot_oe` and `mem_rd` are low.
- R2: A read starts only when `cmdv`=1 and `cmd`=3'b100 in the command cycle (cycle 1). Address word bits [20:19] pick the array: 00 gives `mem_sel`=0 (data), 01 gives `mem_sel`=1 (mask), and 10 or 11 get no response.
- R3: The device responds when address word bits [25:21] equal `dev_id`. When those bits are 11111 it responds only if `last_dev`=1. A device that does not respond never raises `dq_oe`, `ack_oe` or `eot_oe`.
- R4: In cycles 2 and 3 all three enables are low. In cycle 4, `dq_oe`, `ack_oe` and `eot_oe` are all high, while `ack_out` and `eot_out` are low.
- R5: For access k (k = 0 to n-1), cycle 5+2k drives `dq_out` with the array word at address start+k and holds `ack_out` high. In each even cycle between two data cycles, `dq_oe` stays high and `ack_out` is low.
- R6: `eot_out` is high only in the data cycle of the last access, cycle 3+2n.
- R7: In cycle 4+2n, `dq_oe` is low while `ack_oe` and `eot_oe` are high with both strobes low. In the following cycle all enables are low, so a burst lasts exactly 4+2n cycles.
- R8: The array address comes from the burst register counter. It advances by one per access, wraps modulo 2^15, and carries over into the next burst when the register is not reloaded.
- R9: A programmed burst length of zero runs as one access.
- R10: While a burst runs, both a new read command and a burst register write are ignored. The sequence and the counter are not disturbed by either.
- R11: A burst register write (`cfg_we`=1) in idle sets the start address and the burst length used by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_id | input | 5 | This device's select number |
| last_dev | input | 1 | Marks this device as the last in the chain |
| cfg_we | input | 1 | Burst register write strobe |
| cfg_addr | input | 15 | Start address for the burst register |
| cfg_len | input | 8 | Access count for the burst register |
| cmdv | input | 1 | Command valid |
| cmd | input | 3 | Command code |
| dq_in | input | 68 | Shared bus, value seen by the device |
| dq_out | output | 68 | Shared bus, value driven by the device |
| dq_oe | output | 1 | Bus driver enable |
| ack_out | output | 1 | Acknowledge strobe |
| ack_oe | output | 1 | Acknowledge driver enable |
| eot_out | output | 1 | End-of-transfer strobe |
| eot_oe | output | 1 | End-of-transfer driver enable |
| mem_rd | output | 1 | Array read request |
| mem_sel | output | 1 | Array select, 0 data and 1 mask |
| mem_addr | output | 15 | Array read address |
| mem_data | input | 68 | Array read data, one cycle after `mem_rd` |

## Verification
The bench targets the broadcast select code. A design that compares the field only against `dev_id` would either answer on every chain member or on none. It sends reserved array codes and wrong command codes, where a loose decoder would grab the bus. It runs bursts of length zero, which a naive countdown turns into 256 accesses, and it runs a burst that crosses the top of the address space to expose a missing wrap. It also fires a command and a register write in the middle of a burst: a responder that restarts or reloads would show a shifted data cycle or a wrong address in the following burst.

// File: rtl/burst_read_responder.sv
module burst_read_responder #(
  parameter int DQ_W  = 68,
  parameter int AW    = 15,
  parameter int LEN_W = 8,
  parameter int ID_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  dev_id,
  input  logic             last_dev,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cmdv,
  input  logic [2:0]       cmd,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic             ack_out,
  output logic             ack_oe,
  output logic             eot_out,
  output logic             eot_oe,
  output logic             mem_rd,
  output logic             mem_sel,
  output logic [AW-1:0]    mem_addr,
  input  logic [DQ_W-1:0]  mem_data
);
  localparam int            ID_LSB  = 21;
  localparam int            ARR_LSB = 19;
  localparam logic [ID_W-1:0] BCAST = '1;
  localparam logic [2:0]    RD_CODE = 3'b100;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LEAD, S_DATA, S_TAIL} st_t;

  st_t              st;
  logic             gap_q;
  logic             sel_q;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] left_q;

  wire [ID_W-1:0] id_f  = dq_in[ID_LSB +: ID_W];
  wire [1:0]      arr_f = dq_in[ARR_LSB +: 2];
  wire id_hit  = (id_f == BCAST) ? last_dev : (id_f == dev_id);
  wire go      = (st == S_IDLE) && cmdv && (cmd == RD_CODE) && id_hit && !arr_f[1];
  wire last_ac = (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      gap_q  <= 1'b0;
      sel_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_we) begin
            addr_q <= cfg_addr;
            len_q  <= cfg_len;
          end
          if (go) begin
            st     <= S_GAP;
            gap_q  <= 1'b0;
            sel_q  <= arr_f[0];
            left_q <= (len_q == '0) ? LEN_W'(1) : len_q;
          end
        end
        S_GAP: begin
          gap_q <= 1'b1;
          if (gap_q) st <= S_LEAD;
        end
        S_LEAD: begin
          st     <= S_DATA;
          addr_q <= addr_q + AW'(1);
        end
        S_DATA: begin
          left_q <= left_q - LEN_W'(1);
          st     <= last_ac ? S_TAIL : S_LEAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd   = (st == S_LEAD);
  assign mem_sel  = sel_q;
  assign mem_addr = addr_q;
  assign dq_oe    = (st == S_LEAD) || (st == S_DATA);
  assign dq_out   = (st == S_DATA) ? mem_data : '0;
  assign ack_oe   = dq_oe || (st == S_TAIL);
  assign eot_oe   = ack_oe;
  assign ack_out  = (st == S_DATA);
  assign eot_out  = (st == S_DATA) && last_ac;
endmodule

module burst_read_responder_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dq_oe,
  input logic          ack_oe,
  input logic          eot_oe,
  input logic          ack_out,
  input logic          eot_out,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr
);
  AST_ACK_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n) ack_out |-> (dq_oe && ack_oe)); // R5
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack_out |=> !ack_out); // R5
  AST_EOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) eot_out |-> (ack_out && eot_oe)); // R6
  AST_EOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n) eot_out |=> (!dq_oe && ack_oe && !ack_out)); // R7
  AST_BUS_UNDER_STROBES: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (ack_oe && eot_oe)); // R4
  AST_LEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ack_oe) |-> (dq_oe && !ack_out && !eot_out)); // R4
  AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (ack_oe && !dq_oe) |=> !ack_oe); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> (mem_addr == $past(mem_addr) + AW'(1))); // R8
  AST_RD_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> ack_out); // R5
endmodule

bind burst_read_responder burst_read_responder_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .ack_oe(ack_oe), .eot_oe(eot_oe),
  .ack_out(ack_out), .eot_out(eot_out), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/test_burst_read_responder.sv
module test_burst_read_responder;
  localparam int DQ_W = 68;
  localparam int AW   = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      dev_id = 5'd9;
  logic            last_dev = 1'b0;
  logic            cfg_we = 1'b0;
  logic [AW-1:0]   cfg_addr = '0;
  logic [7:0]      cfg_len = '0;
  logic            cmdv = 1'b0;
  logic [2:0]      cmd = '0;
  logic [DQ_W-1:0] dq_in = '0;
  logic [DQ_W-1:0] dq_out;
  logic            dq_oe, ack_out, ack_oe, eot_out, eot_oe, mem_rd, mem_sel;
  logic [AW-1:0]   mem_addr;
  logic [DQ_W-1:0] mem_data = '0;

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] exp_addr = '0;

  always #2 clk = ~clk;

  burst_read_responder i_burst_read_responder (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .last_dev(last_dev),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
    .cmdv(cmdv), .cmd(cmd), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .ack_out(ack_out), .ack_oe(ack_oe),
    .eot_out(eot_out), .eot_oe(eot_oe), .mem_rd(mem_rd), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  function automatic logic [DQ_W-1:0] pat(input logic s, input logic [AW-1:0] a);
    return {(s ? 16'h5A5A : 16'hA5A5), 22'h0, a, ~a};
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= pat(mem_sel, mem_addr);

  task automatic chk(input string r, input string what, input logic [DQ_W-1:0] act, input logic [DQ_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] ctl();
    return DQ_W'({dq_oe, ack_oe, eot_oe, ack_out, eot_out});
  endfunction

  task automatic cfg(input logic [AW-1:0] a, input logic [7:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_len = l;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_addr = a;
  endtask

  // One read: cycle 1 is the cycle with cmdv high; checks cycles 2 .. 4+2n+1.
  task automatic burst(input string r, input logic [4:0] idf, input logic [1:0] arr,
                       input logic [2:0] code, input logic hit, input int n, input logic poke);
    int last_c;
    @(negedge clk);
    cmdv = 1'b1; cmd = code;
    dq_in = '0; dq_in[25:21] = idf; dq_in[20:19] = arr;
    @(negedge clk);
    cmdv = 1'b0; cmd = '0; dq_in = '0;
    last_c = 4 + 2 * n;
    for (int c = 2; c <= last_c + 1; c++) begin
      if (!hit || c < 4 || c > last_c)
        chk(r, $sformatf("cycle %0d quiet", c), ctl(), '0);
      else if (c == last_c)
        chk(r, "final cycle R7", ctl(), DQ_W'(5'b01100));
      else if (c % 2 == 0)
        chk(r, $sformatf("lead cycle %0d R4", c), ctl(), DQ_W'(5'b11100));
      else begin
        chk(r, $sformatf("data cycle %0d ctl R5 R6", c), ctl(),
            DQ_W'({4'b1111, (c == last_c - 1)}));
        chk(r, $sformatf("data cycle %0d word R8", c), dq_out,
            pat(arr[0], exp_addr + AW'((c - 5) / 2)));
      end
      if (poke && c == 6) begin
        cmdv = 1'b1; cmd = 3'b100; dq_in[25:21] = dev_id;
        cfg_we = 1'b1; cfg_addr = 15'h0055; cfg_len = 8'd1;
      end else begin
        cmdv = 1'b0; cmd = '0; dq_in = '0; cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    if (hit) exp_addr = exp_addr + AW'(n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "enables in reset", DQ_W'({dq_oe, ack_oe, eot_oe, mem_rd}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "enables after reset", DQ_W'({dq_oe, ack_oe, eot_oe, mem_rd}), '0);
  endtask

  task automatic t_data();
    cfg(15'd100, 8'd4);
    burst("R11", dev_id, 2'b00, 3'b100, 1'b1, 4, 1'b0);
  endtask

  task automatic t_mask_carry();
    burst("R2", dev_id, 2'b01, 3'b100, 1'b1, 4, 1'b0);
  endtask

  task automatic t_select();
    last_dev = 1'b1;
    burst("R3", 5'b11111, 2'b00, 3'b100, 1'b1, 4, 1'b0);
    last_dev = 1'b0;
    burst("R3", 5'b11111, 2'b00, 3'b100, 1'b0, 1, 1'b0);
    burst("R3", 5'd10, 2'b00, 3'b100, 1'b0, 1, 1'b0);
  endtask

  task automatic t_decode();
    burst("R2", dev_id, 2'b10, 3'b100, 1'b0, 1, 1'b0);
    burst("R2", dev_id, 2'b11, 3'b100, 1'b0, 1, 1'b0);
    burst("R2", dev_id, 2'b00, 3'b101, 1'b0, 1, 1'b0);
    burst("R2", dev_id, 2'b00, 3'b000, 1'b0, 1, 1'b0);
  endtask

  task automatic t_zero_len();
    cfg(15'd7, 8'd0);
    burst("R9", dev_id, 2'b01, 3'b100, 1'b1, 1, 1'b0);
  endtask

  task automatic t_wrap();
    cfg(15'h7FFE, 8'd3);
    burst("R8", dev_id, 2'b00, 3'b100, 1'b1, 3, 1'b0);
  endtask

  task automatic t_busy();
    cfg(15'd300, 8'd3);
    burst("R10", dev_id, 2'b00, 3'b100, 1'b1, 3, 1'b1);
    burst("R10", dev_id, 2'b01, 3'b100, 1'b1, 3, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_data();
    t_mask_carry();
    t_select();
    t_decode();
    t_zero_len();
    t_wrap();
    t_busy();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule